// File: doc/BRIEF.md
# Dual-Port Claim Tag Register

This block holds a small set of claim tags. Two independent agents use these bits to agree on who owns a shared debug resource. One agent is the processor, through its system-register port. The other is an external debugger, through the debug port. Each port writes through one of two views and reads through either view:

- **Set view.** Writing a one sets the matching tag bit. Reading this view returns a fixed mask of the implemented tag bits.
- **Clear view.** Writing a one clears the matching tag bit. Reading this view returns the current tags.

Writes can arrive on both ports in the same cycle. The block does not pick a winner between the ports. It merges the one-bits of every write, so that no write is lost. The result is the same whichever order the two writes could have been applied in.

All writes go into one state register. Both ports therefore observe the same, single sequence of tag values.

Top module: `claim_tag_dual`

## Requirements
- R1: A write to the set view (view select 0) sets every tag bit whose data bit is 1. Tag bits whose data bit is 0 keep their value.
- R2: A write to the clear view (view select 1) clears every tag bit whose data bit is 1. Tag bits whose data bit is 0 keep their value.
- R3: On either port, a read with view select 1 returns the current tag value.
- R4: On either port, a read with view select 0 returns the implemented-bit mask, which is 0xFF by default.
- R5: When both ports write the set view in the same cycle, the new tags are the old tags ORed with both data words. From 0x00, writes of 0x01 and 0x02 give 0x03.
- R6: When one port writes the set view and the other writes the clear view in the same cycle, on different bits, both writes take effect. From 0x03, a set of 0x04 with a clear of 0x01 gives 0x06.
- R7: When the same bit is set by one port and cleared by the other in the same cycle, the set wins for that bit. This is the default setting of the SET_WINS parameter.
- R8: While rst_n is low at a clock edge, all tag bits become 0.
- R9: A write takes effect at the clock edge where it is presented. From the next cycle on, both ports read the same updated value.
- R10: A port with its write enable low changes no tag bit, whatever its data and view inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_wr_en | input | 1 | Write strobe, system-register port |
| sys_wr_view | input | 1 | Write view, system port: 0 selects the set view, 1 the clear view |
| sys_wr_data | input | TAG_W | Write data, system port |
| sys_rd_view | input | 1 | Read view, system port: 0 returns the mask, 1 returns the tags |
| sys_rd_data | output | TAG_W | Read data, system port |
| ext_wr_en | input | 1 | Write strobe, external debug port |
| ext_wr_view | input | 1 | Write view, debug port: 0 selects the set view, 1 the clear view |
| ext_wr_data | input | TAG_W | Write data, debug port |
| ext_rd_view | input | 1 | Read view, debug port: 0 returns the mask, 1 returns the tags |
| ext_rd_data | output | TAG_W | Read data, debug port |

## Verification
The bench targets the following corner cases. Each names what a faulty design would show.

- **Same-cycle set on both ports.** A design that prioritises one port would drop the other port's bits. It would show 0x01 or 0x02 instead of 0x03.
- **Set on one port, clear on the other.** A design that does not merge would lose either the set or the clear. It would show 0x04, 0x07 or 0x02 instead of 0x06.
- **Set and clear on the same bit in one cycle.** A design that lets the clear win would leave that bit at 0.
- **Zero data bits.** These must leave their tag bits alone. A design that copies the data into the register instead of using it as a mask would wipe unrelated tags.
- **Disabled write enable.** A design that ignores the enable would change the tags even though no write was made.
- **Random traffic and mid-run reset.** A long run of random traffic, with a reset in the middle, compares both read ports every cycle against an independent per-bit model. This catches views crossed between the ports and updates that arrive a cycle late.

// File: rtl/claim_pkg.sv
// Package: shared types for the dual-port claim tag block.
// Assumes a one-bit view select on every read and write path.
package claim_pkg;

    // Which register view an access targets.
    typedef enum logic {
        VIEW_SET = 1'b0,
        VIEW_CLR = 1'b1
    } claim_view_e;

    // Port indices used inside the block.
    localparam int unsigned PORT_SYS = 0;
    localparam int unsigned PORT_EXT = 1;
    localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/claim_port_decode.sv
// Module: claim_port_decode
// Turns one port's write strobe, view and data into a set mask and a clear
// mask. Bits outside the implemented mask are dropped here.
// Assumes at most one write per port per cycle.
module claim_port_decode
    import claim_pkg::*;
#(
    parameter int unsigned TAG_W = 8,
    parameter logic [TAG_W-1:0] IMPL_MASK = '1
) (
    input  logic             wr_en,
    input  logic             wr_view,
    input  logic [TAG_W-1:0] wr_data,
    output logic [TAG_W-1:0] set_mask,
    output logic [TAG_W-1:0] clr_mask
);

    claim_view_e view;
    logic [TAG_W-1:0] eff_data;

    // Interpret the raw view bit and keep only the implemented bits.
    always_comb begin
        view     = claim_view_e'(wr_view);
        eff_data = wr_data & IMPL_MASK;
    end

    // Route the data to the set path or the clear path, only when enabled.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (wr_en) begin
            if (view == VIEW_SET) begin
                set_mask = eff_data;
            end else begin
                clr_mask = eff_data;
            end
        end
    end

endmodule

// File: rtl/claim_merge.sv
// Module: claim_merge
// Combines the set and clear masks from every port with the current tags.
// One-bits from all ports are ORed, so no port's write is lost.
// SET_WINS chooses how a bit that is both set and cleared in one cycle
// resolves. Purely combinational.
module claim_merge #(
    parameter int unsigned TAG_W     = 8,
    parameter int unsigned NUM_PORTS = 2,
    parameter bit          SET_WINS  = 1'b1
) (
    input  logic [TAG_W-1:0] cur_tags,
    input  logic [TAG_W-1:0] set_vec [NUM_PORTS],
    input  logic [TAG_W-1:0] clr_vec [NUM_PORTS],
    output logic [TAG_W-1:0] nxt_tags
);

    logic [TAG_W-1:0] set_any;
    logic [TAG_W-1:0] clr_any;

    // OR together the requests of all ports.
    always_comb begin
        set_any = '0;
        clr_any = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            set_any = set_any | set_vec[p];
            clr_any = clr_any | clr_vec[p];
        end
    end

    // Resolve bits that are set and cleared in the same cycle.
    generate
        if (SET_WINS) begin : g_set_wins
            // The clear is applied first, so the set overrides it.
            always_comb nxt_tags = (cur_tags & ~clr_any) | set_any;
        end else begin : g_clr_wins
            // The set is applied first, so the clear overrides it.
            always_comb nxt_tags = (cur_tags | set_any) & ~clr_any;
        end
    endgenerate

endmodule

// File: rtl/claim_tag_store.sv
// Module: claim_tag_store
// The single state register for the claim tags. Every write goes through
// here, so both ports see one serialized sequence of values.
// Synchronous active-low reset clears all tags. Bits outside IMPL_MASK
// are held at zero.
module claim_tag_store #(
    parameter int unsigned TAG_W = 8,
    parameter logic [TAG_W-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] nxt_tags,
    output logic [TAG_W-1:0] tags
);

    // Load the merged value on each clock edge, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags <= '0;
        end else begin
            tags <= nxt_tags & IMPL_MASK;
        end
    end

endmodule

// File: rtl/claim_read_mux.sv
// Module: claim_read_mux
// Read path for one port. The clear view returns the live tags; the set
// view returns the constant mask of implemented bits. Combinational.
module claim_read_mux
    import claim_pkg::*;
#(
    parameter int unsigned TAG_W = 8,
    parameter logic [TAG_W-1:0] IMPL_MASK = '1
) (
    input  logic             rd_view,
    input  logic [TAG_W-1:0] tags,
    output logic [TAG_W-1:0] rd_data
);

    // Choose between the constant mask and the live tags.
    always_comb begin
        if (claim_view_e'(rd_view) == VIEW_CLR) begin
            rd_data = tags;
        end else begin
            rd_data = IMPL_MASK;
        end
    end

endmodule

// File: rtl/claim_tag_dual.sv
// Module: claim_tag_dual
// Top of the dual-port claim tag block. One decoder and one read mux are
// built per port. The decoders feed a shared merge stage and the single
// tag register.
// Assumes both ports share clk and rst_n. Writes take effect at the edge
// where they are presented.
module claim_tag_dual
    import claim_pkg::*;
#(
    parameter int unsigned TAG_W = 8,
    parameter logic [TAG_W-1:0] IMPL_MASK = '1,
    parameter bit SET_WINS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_wr_en,
    input  logic             sys_wr_view,
    input  logic [TAG_W-1:0] sys_wr_data,
    input  logic             sys_rd_view,
    output logic [TAG_W-1:0] sys_rd_data,
    input  logic             ext_wr_en,
    input  logic             ext_wr_view,
    input  logic [TAG_W-1:0] ext_wr_data,
    input  logic             ext_rd_view,
    output logic [TAG_W-1:0] ext_rd_data
);

    localparam int unsigned NP = NUM_PORTS;

    logic             wr_en_a   [NP];
    logic             wr_view_a [NP];
    logic [TAG_W-1:0] wr_data_a [NP];
    logic             rd_view_a [NP];
    logic [TAG_W-1:0] rd_data_a [NP];
    logic [TAG_W-1:0] set_vec   [NP];
    logic [TAG_W-1:0] clr_vec   [NP];
    logic [TAG_W-1:0] tags;
    logic [TAG_W-1:0] nxt_tags;

    // Gather the named port pins into per-port arrays.
    always_comb begin
        wr_en_a[PORT_SYS]   = sys_wr_en;
        wr_view_a[PORT_SYS] = sys_wr_view;
        wr_data_a[PORT_SYS] = sys_wr_data;
        rd_view_a[PORT_SYS] = sys_rd_view;
        wr_en_a[PORT_EXT]   = ext_wr_en;
        wr_view_a[PORT_EXT] = ext_wr_view;
        wr_data_a[PORT_EXT] = ext_wr_data;
        rd_view_a[PORT_EXT] = ext_rd_view;
    end

    // Drive the read data back out on the named pins.
    always_comb begin
        sys_rd_data = rd_data_a[PORT_SYS];
        ext_rd_data = rd_data_a[PORT_EXT];
    end

    generate
        for (genvar p = 0; p < NP; p++) begin : g_port
            claim_port_decode #(
                .TAG_W    (TAG_W),
                .IMPL_MASK(IMPL_MASK)
            ) i_decode (
                .wr_en   (wr_en_a[p]),
                .wr_view (wr_view_a[p]),
                .wr_data (wr_data_a[p]),
                .set_mask(set_vec[p]),
                .clr_mask(clr_vec[p])
            );

            claim_read_mux #(
                .TAG_W    (TAG_W),
                .IMPL_MASK(IMPL_MASK)
            ) i_read (
                .rd_view(rd_view_a[p]),
                .tags   (tags),
                .rd_data(rd_data_a[p])
            );
        end
    endgenerate

    claim_merge #(
        .TAG_W    (TAG_W),
        .NUM_PORTS(NP),
        .SET_WINS (SET_WINS)
    ) i_merge (
        .cur_tags(tags),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .nxt_tags(nxt_tags)
    );

    claim_tag_store #(
        .TAG_W    (TAG_W),
        .IMPL_MASK(IMPL_MASK)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .nxt_tags(nxt_tags),
        .tags    (tags)
    );

endmodule

// File: rtl/claim_tag_dual_chk.sv
// Module: claim_tag_dual_chk
// Property checker for claim_tag_dual. It is attached with the bind below.
// The per-port requests are rebuilt from the top-level pins, and the
// properties relate them to the tag register and the read outputs.
module claim_tag_dual_chk #(
    parameter int unsigned TAG_W = 8,
    parameter logic [TAG_W-1:0] IMPL_MASK = '1,
    parameter bit SET_WINS = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_wr_en,
    input logic             sys_wr_view,
    input logic [TAG_W-1:0] sys_wr_data,
    input logic             sys_rd_view,
    input logic [TAG_W-1:0] sys_rd_data,
    input logic             ext_wr_en,
    input logic             ext_wr_view,
    input logic [TAG_W-1:0] ext_wr_data,
    input logic             ext_rd_view,
    input logic [TAG_W-1:0] ext_rd_data,
    input logic [TAG_W-1:0] tags
);

    logic [TAG_W-1:0] req_set;
    logic [TAG_W-1:0] req_clr;

    // Requested set and clear bits across both ports, seen at the pins.
    always_comb begin
        req_set = ({TAG_W{sys_wr_en & ~sys_wr_view}} & sys_wr_data)
                | ({TAG_W{ext_wr_en & ~ext_wr_view}} & ext_wr_data);
        req_clr = ({TAG_W{sys_wr_en &  sys_wr_view}} & sys_wr_data)
                | ({TAG_W{ext_wr_en &  ext_wr_view}} & ext_wr_data);
        req_set = req_set & IMPL_MASK;
        req_clr = req_clr & IMPL_MASK;
    end

    // R8: reset empties the tags.
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> tags == '0);

    // R1, R5: requested set bits that nobody clears are 1 afterwards.
    p_set_applies_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((tags & $past(req_set & ~req_clr)) == $past(req_set & ~req_clr)));

    // R2, R6: requested clear bits that nobody sets are 0 afterwards.
    p_clr_applies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((tags & $past(req_clr & ~req_set)) == '0));

    // R1, R2, R10: untouched bits hold their value.
    p_untouched_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((tags ^ $past(tags)) & ~$past(req_set | req_clr)) == '0));

    // R7: a bit both set and cleared in one cycle follows SET_WINS.
    p_conflict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((tags & $past(req_set & req_clr)) ==
                  (SET_WINS ? $past(req_set & req_clr) : '0)));

    // R3: the clear view reads the live tags on each port.
    p_sys_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rd_view |-> sys_rd_data == tags);
    p_ext_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rd_view |-> ext_rd_data == tags);

    // R4: the set view reads the implemented mask.
    p_mask_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rd_view |-> sys_rd_data == IMPL_MASK) and
        (!ext_rd_view |-> ext_rd_data == IMPL_MASK));

    // R9: both ports reading the clear view agree.
    p_ports_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rd_view && ext_rd_view) |-> sys_rd_data == ext_rd_data);

endmodule

bind claim_tag_dual claim_tag_dual_chk #(
    .TAG_W    (TAG_W),
    .IMPL_MASK(IMPL_MASK),
    .SET_WINS (SET_WINS)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_wr_en  (sys_wr_en),
    .sys_wr_view(sys_wr_view),
    .sys_wr_data(sys_wr_data),
    .sys_rd_view(sys_rd_view),
    .sys_rd_data(sys_rd_data),
    .ext_wr_en  (ext_wr_en),
    .ext_wr_view(ext_wr_view),
    .ext_wr_data(ext_wr_data),
    .ext_rd_view(ext_rd_view),
    .ext_rd_data(ext_rd_data),
    .tags       (tags)
);

// File: tb/test_claim_tag_dual.sv
`timescale 1ns/1ps
// Bench for claim_tag_dual. A per-bit behavioural model is advanced on
// every clock. Both read ports are compared with it in every step.
module test_claim_tag_dual;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sys_wr_en = 1'b0, sys_wr_view = 1'b0, sys_rd_view = 1'b1;
    logic [W-1:0] sys_wr_data = '0;
    logic         ext_wr_en = 1'b0, ext_wr_view = 1'b0, ext_rd_view = 1'b1;
    logic [W-1:0] ext_wr_data = '0;
    logic [W-1:0] sys_rd_data, ext_rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit model [W];

    always #2 clk = ~clk;

    claim_tag_dual i_claim_tag_dual (
        .clk(clk), .rst_n(rst_n),
        .sys_wr_en(sys_wr_en), .sys_wr_view(sys_wr_view), .sys_wr_data(sys_wr_data),
        .sys_rd_view(sys_rd_view), .sys_rd_data(sys_rd_data),
        .ext_wr_en(ext_wr_en), .ext_wr_view(ext_wr_view), .ext_wr_data(ext_wr_data),
        .ext_rd_view(ext_rd_view), .ext_rd_data(ext_rd_data)
    );

    // Pack the model bits into a byte for comparison.
    function automatic logic [W-1:0] model_val();
        logic [W-1:0] v;
        for (int b = 0; b < W; b++) v[b] = model[b];
        return v;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // Compare each read port against the model, according to its view.
    task automatic check_reads(string req);
        check(req, sys_rd_data, sys_rd_view ? model_val() : 8'hFF);
        check(req, ext_rd_data, ext_rd_view ? model_val() : 8'hFF);
    endtask

    // One cycle: drive inputs at the falling edge, check the reads,
    // then advance the model across the rising edge.
    task automatic step(string req, bit rst,
                        bit se, bit sv, logic [W-1:0] sd, bit srv,
                        bit ee, bit ev, logic [W-1:0] ed, bit erv);
        @(negedge clk);
        rst_n = ~rst;
        sys_wr_en = se; sys_wr_view = sv; sys_wr_data = sd; sys_rd_view = srv;
        ext_wr_en = ee; ext_wr_view = ev; ext_wr_data = ed; ext_rd_view = erv;
        #1;
        check_reads(req);
        @(posedge clk);
        for (int b = 0; b < W; b++) begin
            bit s, c;
            s = (se && !sv && sd[b]) || (ee && !ev && ed[b]);
            c = (se &&  sv && sd[b]) || (ee &&  ev && ed[b]);
            if (rst) model[b] = 1'b0;
            else if (s) model[b] = 1'b1;
            else if (c) model[b] = 1'b0;
        end
    endtask

    // Let the last step's edge settle, then read both ports in clear view.
    task automatic observe(string req);
        step(req, 0, 0, 0, 8'h00, 1, 0, 0, 8'h00, 1);
    endtask

    initial begin
        for (int b = 0; b < W; b++) model[b] = 1'b0;
        // R8: reset state
        step("R8", 1, 1, 0, 8'hFF, 1, 0, 0, 8'h00, 1);
        step("R8", 1, 0, 0, 8'h00, 1, 0, 0, 8'h00, 1);
        check("R8", sys_rd_data, 8'h00);
        // R5: both ports set in the same cycle, 0x00 -> 0x03
        step("R5", 0, 1, 0, 8'h01, 1, 1, 0, 8'h02, 1);
        observe("R5");
        check("R5", sys_rd_data, 8'h03);
        check("R9", ext_rd_data, 8'h03);
        // R6: set 0x04 on one port, clear 0x01 on the other -> 0x06
        step("R6", 0, 1, 0, 8'h04, 1, 1, 1, 8'h01, 1);
        observe("R6");
        check("R6", ext_rd_data, 8'h06);
        // R7: the same bit set and cleared together stays set -> 0x16
        step("R7", 0, 1, 1, 8'h10, 1, 1, 0, 8'h10, 1);
        observe("R7");
        check("R7", sys_rd_data, 8'h16);
        // R10: disabled writes with all-ones data change nothing
        step("R10", 0, 0, 1, 8'hFF, 1, 0, 0, 8'hFF, 1);
        observe("R10");
        check("R10", sys_rd_data, 8'h16);
        // R1: zero data bits leave other tags alone -> 0x96
        step("R1", 0, 1, 0, 8'h80, 1, 0, 0, 8'h00, 1);
        observe("R1");
        check("R1", sys_rd_data, 8'h96);
        // R2: clear view, single port -> 0x94
        step("R2", 0, 0, 0, 8'h00, 1, 1, 1, 8'h02, 1);
        observe("R2");
        check("R2", ext_rd_data, 8'h94);
        // R4: set view reads the mask on both ports
        step("R4", 0, 0, 0, 8'h00, 0, 0, 0, 8'h00, 0);
        check("R4", sys_rd_data, 8'hFF);
        check("R4", ext_rd_data, 8'hFF);
        // R3 / R9: random traffic on both ports, reads compared every cycle
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom();
            step((i == 1000) ? "R8" : "R3", (i == 1000),
                 r[0], r[1], r[15:8], r[2], r[3], r[4], r[23:16], r[5]);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule